// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware sequencer for a three-wire serial EEPROM. It drives chip select, serial clock and serial data toward the memory, and it samples the memory's data line. A one-cycle start request reads a single 16-bit word at a 6-bit word address. A station-address mode reads words 0 to 11 in order. From that run it builds a 48-bit station address out of a bit field that is stored reversed and crosses word boundaries.

Each read is wrapped in an idle clocking sequence, both before and after. A long run of clock pulses with chip select held is followed by a release of chip select. This brings the memory back to a known state whatever it was doing before. A programmable divider sets how many system clocks each clock phase lasts, so the same logic meets the memory's phase timing (about 2 us) at any system clock rate.

Top module: `eeprom_word_fetch`

## Requirements
- R1: After reset, chip select, serial clock, serial data out, busy and done are all low. Chip select stays low whenever the block is not busy.
- R2: Every word read starts and ends with an idle sequence. In it, chip select is held high for IDLE_PULSES (26) low-then-high clock pulses, the clock is driven low for one phase, and then chip select is released for one phase. A serial clock rising edge only ever occurs while chip select is high.
- R3: After the leading idle sequence comes one extra low-then-high clock cycle. The block then shifts out an 11-bit command, most significant bit first: two zeros, a start bit of 1, read opcode 10, then the 6-bit word address (the value 0x180 OR address). Each bit is set up for one phase with the clock low, then clocked with one high phase and one low phase.
- R4: Sixteen data bits follow, most significant bit first. Each bit is sampled at the end of a clock high phase, after which the clock is driven low. The assembled value appears on word_o.
- R5: Every clock phase lasts exactly PHASE_CLKS system clocks. The serial clock changes only at a phase boundary.
- R6: A single word read gives exactly 80 serial clock rising edges (26 + 1 + 11 + 16 + 26) and exactly two chip select releases.
- R7: done_o pulses high for exactly one cycle when the result is valid. busy_o is high from the cycle after an accepted start until that pulse.
- R8: A start request that arrives while busy_o is high is ignored, whatever its mode and address. No extra read is queued, and the current result is unchanged.
- R9: In station-address mode (mode_i = 1) the block reads word addresses 0 through 11, in increasing order, in one request.
- R10: In station-address mode, output bit i (i = 0..47) equals bit (15 - j mod 16) of word j/16, where j = 111 + i. Bit i lands in byte i/8, bit position i mod 8; byte 0 is station_o[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle read request, honoured only when idle |
| mode_i | input | 1 | 0: single word at addr_i; 1: station-address run |
| addr_i | input | 6 | Word address for a single read |
| ee_cs_o | output | 1 | Memory chip select |
| ee_sk_o | output | 1 | Memory serial clock |
| ee_di_o | output | 1 | Serial data toward the memory |
| ee_do_i | input | 1 | Serial data from the memory |
| word_o | output | 16 | Most recently read word |
| station_o | output | 48 | Rebuilt station address, byte 0 in bits 7:0 |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench builds the block with PHASE_CLKS = 3 and the default 26-pulse idle sequence. A phase of several clocks shows that the divider stretches every phase evenly and that the clock never moves inside a phase, while a full 12-word station run still fits in a few thousand cycles. The address width stays at 6, so the directed reads at addresses 0 and 63 reach both ends of the command field, and a behavioural memory model decodes each command it receives.

// File: rtl/eewf_pkg.sv
package eewf_pkg;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_PRE,
        EN_LEAD,
        EN_CMD,
        EN_DATA,
        EN_POST
    } eng_state_e;

    localparam logic [1:0] READ_OP    = 2'b10;
    localparam int         LEAD_ZEROS = 2;

endpackage

// File: rtl/eewf_phase_timer.sv
module eewf_phase_timer #(
    parameter int PHASE_CLKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (PHASE_CLKS <= 1) begin : g_direct
            assign tick_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(PHASE_CLKS);
            localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run_i)
                    cnt_d = '0;
                else if (cnt_q == LAST)
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = run_i && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/eewf_shift_engine.sv
module eewf_shift_engine
    import eewf_pkg::*;
#(
    parameter int PHASE_CLKS  = 200,
    parameter int IDLE_PULSES = 26,
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              do_i,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    localparam int CMD_W      = ADDR_W + LEAD_ZEROS + 3;
    localparam int IDLE_STEPS = 2 * IDLE_PULSES + 2;
    localparam int STEP_W     = $clog2(IDLE_STEPS);
    localparam int MAXB       = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int BIT_W      = $clog2(MAXB);

    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(IDLE_STEPS - 1);
    localparam logic [STEP_W-1:0] STEP_LOW  = STEP_W'(2 * IDLE_PULSES);
    localparam logic [BIT_W-1:0]  CMD_TOP   = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0]  DATA_TOP  = BIT_W'(WORD_W - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [STEP_W-1:0] step;
        logic [BIT_W-1:0]  bitn;
        logic [1:0]        sub;
        logic [CMD_W-1:0]  cmd;
        logic [WORD_W-1:0] shreg;
        logic              done;
    } eng_regs_t;

    eng_regs_t r_d, r_q;
    logic      tick;

    eewf_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.st != EN_IDLE),
        .tick_o (tick)
    );

    // Next-state: every move except leaving idle waits for a phase boundary.
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            EN_IDLE: begin
                if (go_i) begin
                    r_d.st   = EN_PRE;
                    r_d.step = '0;
                    r_d.cmd  = {{LEAD_ZEROS{1'b0}}, 1'b1, READ_OP, addr_i};
                end
            end
            EN_PRE: begin
                if (tick) begin
                    if (r_q.step == STEP_LAST) begin
                        r_d.st   = EN_LEAD;
                        r_d.step = '0;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                    end
                end
            end
            EN_LEAD: begin
                if (tick) begin
                    if (r_q.step[0]) begin
                        r_d.st   = EN_CMD;
                        r_d.bitn = CMD_TOP;
                        r_d.sub  = 2'd0;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                    end
                end
            end
            EN_CMD: begin
                if (tick) begin
                    if (r_q.sub != 2'd2) begin
                        r_d.sub = r_q.sub + 1'b1;
                    end else if (r_q.bitn == '0) begin
                        r_d.st   = EN_DATA;
                        r_d.bitn = DATA_TOP;
                        r_d.sub  = 2'd0;
                    end else begin
                        r_d.bitn = r_q.bitn - 1'b1;
                        r_d.sub  = 2'd0;
                    end
                end
            end
            EN_DATA: begin
                if (tick) begin
                    if (r_q.sub == 2'd0) begin
                        r_d.shreg = {r_q.shreg[WORD_W-2:0], do_i};
                        r_d.sub   = 2'd1;
                    end else if (r_q.bitn == '0) begin
                        r_d.st   = EN_POST;
                        r_d.step = '0;
                    end else begin
                        r_d.bitn = r_q.bitn - 1'b1;
                        r_d.sub  = 2'd0;
                    end
                end
            end
            EN_POST: begin
                if (tick) begin
                    if (r_q.step == STEP_LAST) begin
                        r_d.st   = EN_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                    end
                end
            end
            default: r_d.st = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= EN_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // Pin decode from registered state only.
    always_comb begin
        cs_o = 1'b0;
        sk_o = 1'b0;
        di_o = 1'b0;
        unique case (r_q.st)
            EN_PRE, EN_POST: begin
                if (r_q.step < STEP_LOW) begin
                    cs_o = 1'b1;
                    sk_o = r_q.step[0];
                end else if (r_q.step == STEP_LOW) begin
                    cs_o = 1'b1;
                end
            end
            EN_LEAD: begin
                cs_o = 1'b1;
                sk_o = r_q.step[0];
            end
            EN_CMD: begin
                cs_o = 1'b1;
                di_o = r_q.cmd[r_q.bitn];
                sk_o = (r_q.sub == 2'd1);
            end
            EN_DATA: begin
                cs_o = 1'b1;
                sk_o = (r_q.sub == 2'd0);
            end
            default: ;
        endcase
    end

    assign word_o = r_q.shreg;
    assign done_o = r_q.done;

    // R5: the serial clock holds its level inside a phase
    a_r5_sk_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sk_o));

    // R2: a clock rising edge only happens with chip select asserted
    a_r2_rise_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_o) |-> cs_o);

endmodule

// File: rtl/eewf_addr_pack.sv
module eewf_addr_pack #(
    parameter int WORD_W   = 16,
    parameter int MAC_OFF  = 111,
    parameter int MAC_BITS = 48
) (
    input  logic [((MAC_OFF + MAC_BITS - 1) / WORD_W - MAC_OFF / WORD_W + 1) * WORD_W - 1:0] words_i,
    output logic [MAC_BITS-1:0] mac_o
);
    localparam int FIRST_W = MAC_OFF / WORD_W;

    // Bit j of the stream is bit (WORD_W-1 - j mod WORD_W) of word j/WORD_W.
    generate
        for (genvar i = 0; i < MAC_BITS; i++) begin : g_bit
            localparam int J = MAC_OFF + i;
            localparam int W = J / WORD_W - FIRST_W;
            localparam int B = WORD_W - 1 - (J % WORD_W);
            assign mac_o[i] = words_i[W * WORD_W + B];
        end
    endgenerate
endmodule

// File: rtl/eeprom_word_fetch.sv
module eeprom_word_fetch #(
    parameter int PHASE_CLKS  = 200,
    parameter int IDLE_PULSES = 26,
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int SCAN_WORDS  = 12,
    parameter int MAC_OFF     = 111,
    parameter int MAC_BITS    = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                ee_cs_o,
    output logic                ee_sk_o,
    output logic                ee_di_o,
    input  logic                ee_do_i,
    output logic [WORD_W-1:0]   word_o,
    output logic [MAC_BITS-1:0] station_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int FIRST_W = MAC_OFF / WORD_W;
    localparam int LAST_W  = (MAC_OFF + MAC_BITS - 1) / WORD_W;
    localparam int KEEP    = LAST_W - FIRST_W + 1;
    localparam logic [ADDR_W-1:0] SCAN_LAST = ADDR_W'(SCAN_WORDS - 1);

    typedef struct packed {
        logic                     busy;
        logic                     station;
        logic [ADDR_W-1:0]        addr;
        logic                     go;
        logic                     done;
        logic [KEEP*WORD_W-1:0]   words;
    } top_regs_t;

    top_regs_t         r_d, r_q;
    logic [WORD_W-1:0] eng_word;
    logic              eng_done;

    eewf_shift_engine #(
        .PHASE_CLKS  (PHASE_CLKS),
        .IDLE_PULSES (IDLE_PULSES),
        .ADDR_W      (ADDR_W),
        .WORD_W      (WORD_W)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (r_q.go),
        .addr_i (r_q.addr),
        .do_i   (ee_do_i),
        .cs_o   (ee_cs_o),
        .sk_o   (ee_sk_o),
        .di_o   (ee_di_o),
        .word_o (eng_word),
        .done_o (eng_done)
    );

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.busy    = 1'b1;
                r_d.station = mode_i;
                r_d.addr    = mode_i ? '0 : addr_i;
                r_d.go      = 1'b1;
            end
        end else if (eng_done) begin
            if (r_q.station) begin
                for (int k = 0; k < KEEP; k++) begin
                    if (r_q.addr == ADDR_W'(FIRST_W + k))
                        r_d.words[k*WORD_W +: WORD_W] = eng_word;
                end
            end
            if (!r_q.station || r_q.addr == SCAN_LAST) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.addr = r_q.addr + 1'b1;
                r_d.go   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    eewf_addr_pack #(
        .WORD_W   (WORD_W),
        .MAC_OFF  (MAC_OFF),
        .MAC_BITS (MAC_BITS)
    ) u_pack (
        .words_i (r_q.words),
        .mac_o   (station_o)
    );

    assign word_o = eng_word;
    assign busy_o = r_q.busy;
    assign done_o = r_q.done;

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: the memory is deselected while no request is running
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ee_cs_o);

    // R8: a request during a run does not change the selected mode
    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(r_q.station));

endmodule

// File: tb/tb_eeprom_word_fetch.sv
module tb_eeprom_word_fetch;
    localparam int PH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic        ee_cs_o, ee_sk_o, ee_di_o;
    logic        ee_do_i;
    logic [15:0] word_o;
    logic [47:0] station_o;
    logic        busy_o, done_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    eeprom_word_fetch #(.PHASE_CLKS(PH)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .addr_i(addr_i), .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o),
        .ee_di_o(ee_di_o), .ee_do_i(ee_do_i), .word_o(word_o),
        .station_o(station_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Behavioural three-wire memory
    logic [15:0] mem [64];
    int          ms = 0, nb = 0, dcnt = 0;
    logic [7:0]  sh = '0;
    logic        eo = 1'b0;
    logic [1:0]  last_op = '0;
    int          addr_log [32];
    int          log_n = 0;
    int          rises = 0, cs_falls = 0, pre_rises = 0;
    int          bad_len = 0, hi_len = 0;

    assign ee_do_i = eo;

    always @(posedge ee_sk_o) begin
        if (ee_cs_o) begin
            rises++;
            if (cs_falls == 0) pre_rises++;
            case (ms)
                0: if (ee_di_o) begin ms = 1; nb = 0; sh = '0; end
                1: begin
                    sh = {sh[6:0], ee_di_o};
                    nb++;
                    if (nb == 8) begin
                        ms = 2; dcnt = 0; eo = 1'b0;
                        last_op = sh[7:6];
                        if (log_n < 32) addr_log[log_n] = int'(sh[5:0]);
                        log_n++;
                    end
                end
                default: begin
                    if (dcnt < 16) begin
                        eo = mem[addr_log[log_n-1]][15-dcnt];
                        dcnt++;
                    end else begin
                        ms = 0; eo = 1'b0;
                    end
                end
            endcase
        end
    end

    always @(negedge ee_cs_o) begin
        cs_falls++;
        ms = 0;
        eo = 1'b0;
    end

    // R5: length of every clock high phase in system clocks
    always @(posedge clk) begin
        if (ee_sk_o) hi_len++;
        else begin
            if (hi_len != 0 && hi_len != PH) bad_len++;
            hi_len = 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_station();
        logic [47:0] r;
        for (int i = 0; i < 48; i++) begin
            int j = 111 + i;
            r[i] = mem[j/16][15 - (j % 16)];
        end
        return r;
    endfunction

    task automatic fill_mem();
        for (int a = 0; a < 64; a++) mem[a] = 16'($urandom);
    endtask

    task automatic clear_counts();
        rises = 0; cs_falls = 0; pre_rises = 0; log_n = 0;
    endtask

    task automatic wait_done(input int limit, output bit seen);
        seen = 1'b0;
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (done_o) begin seen = 1'b1; break; end
        end
    endtask

    task automatic pulse_start(input logic m, input logic [5:0] a);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; addr_i = a;
        @(negedge clk);
        start_i = 1'b0; mode_i = 1'b0; addr_i = '0;
    endtask

    task automatic single_read(input logic [5:0] a);
        bit seen;
        clear_counts();
        pulse_start(1'b0, a);
        check(busy_o == 1'b1, "R7 busy during read", busy_o, 1);
        wait_done(4000, seen);
        check(seen, "R7 done seen", seen, 1);
        check(word_o == mem[a], "R4 word value", word_o, mem[a]);
        check(log_n == 1 && addr_log[0] == int'(a), "R3 command address", addr_log[0], a);
        check(last_op == 2'b10, "R3 read opcode", last_op, 2'b10);
        check(rises == 80, "R6 clock edges", rises, 80);
        check(cs_falls == 2, "R6 chip select releases", cs_falls, 2);
        check(pre_rises == 26, "R2 leading idle pulses", pre_rises, 26);
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R7 done one cycle", {done_o, busy_o}, 0);
    endtask

    task automatic station_read();
        bit seen;
        clear_counts();
        pulse_start(1'b1, 6'd50);
        wait_done(30000, seen);
        check(seen, "R9 station done", seen, 1);
        check(log_n == 12, "R9 word count", log_n, 12);
        for (int k = 0; k < 12 && k < log_n; k++)
            check(addr_log[k] == k, "R9 address order", addr_log[k], k);
        check(station_o == exp_station(), "R10 station bits", station_o, exp_station());
        check(word_o == mem[11], "R9 last word", word_o, mem[11]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd20250611));
        fill_mem();
        repeat (3) @(negedge clk);
        check({ee_cs_o, ee_sk_o, ee_di_o, busy_o, done_o} == 5'b0, "R1 reset pins",
              {ee_cs_o, ee_sk_o, ee_di_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({ee_cs_o, busy_o, done_o} == 3'b0, "R1 idle after reset", {ee_cs_o, busy_o, done_o}, 0);

        single_read(6'd0);
        single_read(6'd63);
        for (int n = 0; n < 5; n++) single_read(6'($urandom_range(0, 63)));

        // R8: second request during a run is dropped
        clear_counts();
        pulse_start(1'b0, 6'd21);
        repeat (100) @(negedge clk);
        pulse_start(1'b1, 6'd5);
        wait_done(4000, seen);
        check(seen && word_o == mem[21], "R8 result kept", word_o, mem[21]);
        check(log_n == 1, "R8 no extra read", log_n, 1);
        repeat (60) @(negedge clk);
        check(busy_o == 1'b0 && ee_cs_o == 1'b0, "R8 nothing queued", {busy_o, ee_cs_o}, 0);

        station_read();
        fill_mem();
        station_read();

        check(bad_len == 0, "R5 phase length", bad_len, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule